// File: doc/BRIEF.md
# Latency-Aware Phase Power-State Selector

This block picks the voltage/frequency operating point for the next phase of a running program. It is consulted once at every phase boundary. The caller presents the predicted phase length in timer ticks, a flag that marks the phase as busy-waiting, the operating point in force now, the point planned for the compute phase that follows, and a precomputed best point for compute phases. One cycle later the block returns the point to apply, whether a power request is worth issuing at all, and how many ticks of voltage-raise latency the move costs.

A waiting phase is judged only by its length, measured against two latency thresholds. The first is the cost of sending a request. The second is the time the supply needs to rise. A very short wait leaves the point alone. A medium wait drops only the frequency. A long wait drops both voltage and frequency to the floor. In every waiting case, any field that sits above what the next compute phase needs is lowered to that phase's value at once. A compute phase takes the supplied best point. Both thresholds are registers in tick units, and the caller can rewrite them. Frequency and voltage are given as level indices, where 0 is the lowest level and a larger index means more power.

Top module: `pstate_phase_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A busy phase with `in_len` less than or equal to the request threshold keeps the current frequency and voltage levels (subject to R5). The comparison is inclusive.
- R3: A busy phase with a length above the request threshold and at most the raise threshold sets the frequency level to 0 and keeps the current voltage level (subject to R5).
- R4: A busy phase longer than the raise threshold sets both the frequency level and the voltage level to 0.
- R5: For a busy phase, each of the two output levels is at most the corresponding level of the following compute phase (`in_nxt_f`, `in_nxt_v`).
- R6: A compute phase outputs `in_opt_f` and `in_opt_v`. `out_lat` equals the raise threshold when `in_opt_v` is greater than `in_cur_v`, and 0 otherwise. A busy phase always has `out_lat` equal to 0.
- R7: `out_issue` is 1 exactly when the output point differs from the current point in frequency or in voltage.
- R8: After reset the request threshold is 2000 ticks and the raise threshold is 240000 ticks (a 1 us tick). A cycle with `cfg_we` high loads both thresholds, and decisions taken from the next cycle onward use the new values.
- R9: A result appears in the cycle after an accepted input (`in_valid` and `in_ready`). It is held stable with `out_valid` high until a cycle with `out_ack` high. `in_ready` is low while a result waits unacknowledged, and input presented then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load both latency thresholds |
| cfg_req_ticks | input | LEN_W | New request-issue threshold |
| cfg_vup_ticks | input | LEN_W | New voltage-raise threshold |
| in_valid | input | 1 | Phase descriptor present |
| in_ready | output | 1 | Descriptor can be accepted |
| in_busy | input | 1 | Phase is busy-waiting |
| in_len | input | LEN_W | Predicted phase length in ticks |
| in_cur_f | input | F_W | Current frequency level |
| in_cur_v | input | V_W | Current voltage level |
| in_nxt_f | input | F_W | Next compute phase frequency level |
| in_nxt_v | input | V_W | Next compute phase voltage level |
| in_opt_f | input | F_W | Best frequency level for a compute phase |
| in_opt_v | input | V_W | Best voltage level for a compute phase |
| out_valid | output | 1 | Result held |
| out_ack | input | 1 | Result consumed |
| out_issue | output | 1 | A power request should be sent |
| out_f | output | F_W | Chosen frequency level |
| out_v | output | V_W | Chosen voltage level |
| out_lat | output | LEN_W | Voltage-raise ticks charged to the move |

## Verification
Two rules can decide the same waiting phase. One is the length test against a threshold, including a length that equals the threshold exactly. The other is the early drop toward the next compute phase. The bench drives lengths that sit on each threshold and one tick past it, and it pairs these with next-phase levels that are below the current ones. The expected point then comes from the keep or frequency-only rule and, applied to the same phase, from the lowering rule. A threshold rewrite in the same cycle as an accepted decision is also driven. That decision must still be judged against the old thresholds.

// File: rtl/pstate_phase_sel.sv
module pstate_phase_sel #(
  parameter int LEN_W         = 32,
  parameter int F_W           = 4,
  parameter int V_W           = 2,
  parameter int DEF_REQ_TICKS = 2000,
  parameter int DEF_VUP_TICKS = 240000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [LEN_W-1:0] cfg_req_ticks,
  input  logic [LEN_W-1:0] cfg_vup_ticks,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_busy,
  input  logic [LEN_W-1:0] in_len,
  input  logic [F_W-1:0]   in_cur_f,
  input  logic [V_W-1:0]   in_cur_v,
  input  logic [F_W-1:0]   in_nxt_f,
  input  logic [V_W-1:0]   in_nxt_v,
  input  logic [F_W-1:0]   in_opt_f,
  input  logic [V_W-1:0]   in_opt_v,
  output logic             out_valid,
  input  logic             out_ack,
  output logic             out_issue,
  output logic [F_W-1:0]   out_f,
  output logic [V_W-1:0]   out_v,
  output logic [LEN_W-1:0] out_lat
);

  logic [LEN_W-1:0] req_q, vup_q;
  logic [F_W-1:0]   wait_f, dec_f;
  logic [V_W-1:0]   wait_v, dec_v;
  logic [LEN_W-1:0] dec_lat;
  logic             accept;

  assign in_ready = !out_valid || out_ack;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= LEN_W'(DEF_REQ_TICKS);
      vup_q <= LEN_W'(DEF_VUP_TICKS);
    end else if (cfg_we) begin
      req_q <= cfg_req_ticks;
      vup_q <= cfg_vup_ticks;
    end
  end

  always_comb begin
    if (in_len <= req_q) begin
      wait_f = in_cur_f;
      wait_v = in_cur_v;
    end else if (in_len <= vup_q) begin
      wait_f = '0;
      wait_v = in_cur_v;
    end else begin
      wait_f = '0;
      wait_v = '0;
    end
    if (wait_f > in_nxt_f) wait_f = in_nxt_f;
    if (wait_v > in_nxt_v) wait_v = in_nxt_v;
  end

  assign dec_f   = in_busy ? wait_f : in_opt_f;
  assign dec_v   = in_busy ? wait_v : in_opt_v;
  assign dec_lat = (!in_busy && in_opt_v > in_cur_v) ? vup_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_issue <= 1'b0;
      out_f     <= '0;
      out_v     <= '0;
      out_lat   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_issue <= (dec_f != in_cur_f) || (dec_v != in_cur_v);
      out_f     <= dec_f;
      out_v     <= dec_v;
      out_lat   <= dec_lat;
    end else if (out_ack) begin
      out_valid <= 1'b0;
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_wait_never_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_busy) |=> (out_f <= $past(in_cur_f) && out_v <= $past(in_cur_v)
                              && out_f <= $past(in_nxt_f) && out_v <= $past(in_nxt_v)));

  assert_compute_takes_opt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_busy) |=> (out_f == $past(in_opt_f) && out_v == $past(in_opt_v)));

  assert_no_lat_when_lowering_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (in_busy || in_opt_v <= in_cur_v)) |=> (out_lat == '0));

  assert_silent_means_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_issue || (out_f == $past(in_cur_f) && out_v == $past(in_cur_v))));

  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_f) && $stable(out_v)
                                 && $stable(out_issue) && $stable(out_lat)));

  assert_not_ready_while_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack) |-> !in_ready);

endmodule

// File: tb/pstate_phase_sel_bench.sv
`timescale 1ns/1ps
module pstate_phase_sel_bench;
  localparam int LEN_W = 32, F_W = 4, V_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [LEN_W-1:0] cfg_req_ticks = '0, cfg_vup_ticks = '0;
  logic in_valid = 1'b0, in_busy = 1'b0, out_ack = 1'b1;
  logic [LEN_W-1:0] in_len = '0;
  logic [F_W-1:0] in_cur_f = '0, in_nxt_f = '0, in_opt_f = '0;
  logic [V_W-1:0] in_cur_v = '0, in_nxt_v = '0, in_opt_v = '0;
  logic in_ready, out_valid, out_issue;
  logic [F_W-1:0] out_f;
  logic [V_W-1:0] out_v;
  logic [LEN_W-1:0] out_lat;

  always #10 clk = ~clk;

  pstate_phase_sel u_pstate_phase_sel (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_req_ticks(cfg_req_ticks),
    .cfg_vup_ticks(cfg_vup_ticks), .in_valid(in_valid), .in_ready(in_ready),
    .in_busy(in_busy), .in_len(in_len), .in_cur_f(in_cur_f), .in_cur_v(in_cur_v),
    .in_nxt_f(in_nxt_f), .in_nxt_v(in_nxt_v), .in_opt_f(in_opt_f), .in_opt_v(in_opt_v),
    .out_valid(out_valid), .out_ack(out_ack), .out_issue(out_issue),
    .out_f(out_f), .out_v(out_v), .out_lat(out_lat));

  int checks = 0, failures = 0;
  string tag = "R1";
  string m_tag = "R1";

  // reference model state
  longint m_req = 2000, m_vup = 240000;
  bit m_valid = 0, m_issue = 0;
  int m_f = 0, m_v = 0;
  longint m_lat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req <= 2000; m_vup <= 240000; m_valid <= 0;
    end else begin
      int f, v; longint lat;
      if (cfg_we) begin m_req <= cfg_req_ticks; m_vup <= cfg_vup_ticks; end
      if (in_valid && (!m_valid || out_ack)) begin
        lat = 0;
        if (in_busy) begin
          if (longint'(in_len) <= m_req) begin f = in_cur_f; v = in_cur_v; end
          else if (longint'(in_len) <= m_vup) begin f = 0; v = in_cur_v; end
          else begin f = 0; v = 0; end
          if (f > int'(in_nxt_f)) f = in_nxt_f;
          if (v > int'(in_nxt_v)) v = in_nxt_v;
        end else begin
          f = in_opt_f; v = in_opt_v;
          if (in_opt_v > in_cur_v) lat = m_vup;
        end
        m_valid <= 1; m_f <= f; m_v <= v; m_lat <= lat;
        m_issue <= (f != int'(in_cur_f)) || (v != int'(in_cur_v));
        m_tag <= tag;
      end else if (m_valid && out_ack) m_valid <= 0;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", out_valid, 0, "out_valid in reset");
    end else begin
      chk("R9", in_ready, (!m_valid || out_ack), "in_ready");
      chk(m_tag, out_valid, m_valid, "out_valid");
      if (m_valid) begin
        chk(m_tag, out_f, m_f, "out_f");
        chk(m_tag, out_v, m_v, "out_v");
        chk("R7", out_issue, m_issue, "out_issue");
        chk("R6", out_lat, m_lat, "out_lat");
      end
    end
  end

  task automatic send(input string t, input bit busy, input longint len,
                      input int cf, input int cv, input int nf, input int nv,
                      input int of, input int ov);
    @(negedge clk);
    tag = t; in_valid = 1; in_busy = busy; in_len = LEN_W'(len);
    in_cur_f = F_W'(cf); in_cur_v = V_W'(cv); in_nxt_f = F_W'(nf); in_nxt_v = V_W'(nv);
    in_opt_f = F_W'(of); in_opt_v = V_W'(ov);
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", out_valid, 0, "out_valid after reset");
    chk("R1", in_ready, 1, "in_ready after reset");
    // R8 default thresholds, inclusive edges, R2/R3/R4
    send("R2", 1, 2000, 9, 3, 15, 3, 0, 0);
    send("R3", 1, 2001, 9, 3, 15, 3, 0, 0);
    send("R3", 1, 240000, 9, 3, 15, 3, 0, 0);
    send("R4", 1, 240001, 9, 3, 15, 3, 0, 0);
    send("R2", 1, 5, 4, 1, 4, 1, 0, 0);
    // R5 early drop combined with keep and frequency-only rules
    send("R5", 1, 2000, 9, 2, 3, 1, 0, 0);
    send("R5", 1, 5000, 9, 3, 5, 1, 0, 0);
    send("R5", 1, 100, 6, 1, 8, 0, 0, 0);
    // R6 compute phases up, down, same
    send("R6", 0, 50, 2, 0, 0, 0, 10, 3);
    send("R6", 0, 50, 10, 3, 0, 0, 2, 1);
    send("R7", 0, 50, 7, 2, 0, 0, 7, 2);
    send("R6", 0, 50, 3, 1, 0, 0, 12, 1);
    // R8 rewrite thresholds in the same cycle as a decision
    @(negedge clk);
    cfg_we = 1; cfg_req_ticks = 10; cfg_vup_ticks = 50;
    tag = "R8"; in_valid = 1; in_busy = 1; in_len = 30;
    in_cur_f = 9; in_cur_v = 3; in_nxt_f = 15; in_nxt_v = 3;
    @(negedge clk);
    cfg_we = 0; in_valid = 0;
    send("R8", 1, 10, 9, 3, 15, 3, 0, 0);
    send("R8", 1, 11, 9, 3, 15, 3, 0, 0);
    send("R8", 1, 50, 9, 3, 15, 3, 0, 0);
    send("R8", 1, 51, 9, 3, 15, 3, 0, 0);
    send("R8", 0, 1, 1, 0, 0, 0, 5, 2);
    // R9 hold without acknowledge, ignored input while held
    @(negedge clk);
    out_ack = 0;
    send("R9", 0, 1, 1, 0, 0, 0, 6, 2);
    send("R9", 1, 999, 9, 3, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    out_ack = 1;
    repeat (2) @(negedge clk);
    send("R9", 1, 999, 9, 3, 2, 1, 0, 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule